// File: doc/BRIEF.md
# Refresh Unlock and Validation Gate

This block sits in front of a watchdog counter and decides whether each refresh attempt that software makes is legitimate. Software writes through a small register-write port. It can load a 16-bit stored key, a timeout period and a configuration byte. It can also present an unlock key, present a refresh word, and clear the status flags. A refresh is legitimate only if four things hold: it carries the one fixed magic word, the counter core reports that the counter is inside its allowed window, an unlock came first (when the lock is enabled), and that unlock happened recently enough (when the timeout is enabled).

The key that software must present is derived from the stored value by one of four selectable rules. This means software never writes the literal stored value unless it has chosen the identity rule. Every refresh attempt consumes the unlock, whether it succeeds or fails. An accepted refresh produces a one-cycle strobe toward the counter core. A rejected refresh sets a sticky violation flag. A wrong unlock key sets a sticky unlock-fail flag. Each flag can drive an interrupt request and a reset request, and each of these four paths has its own enable.

Top module: `refresh_gate`

## Requirements
- R1: After reset, refresh_ok, viol_flag, unl_fail_flag, irq and rst_req are all low. The configuration, stored key and period are zero, and no unlock is held.
- R2: A write to address 4 carrying 0x5A45524F, with window_ok high and no lock requirement unmet, raises refresh_ok for exactly the one cycle after the write edge.
- R3: A write to address 4 with any word other than 0x5A45524F raises viol_flag from the next cycle and gives no refresh_ok.
- R4: A refresh write made while window_ok is low is a violation even if the word is correct.
- R5: With the lock enable (configuration bit 2, written at address 0) set, a refresh that has no held unlock is a violation.
- R6: An unlock is a write to address 3, and its bits 15:0 are compared with an expected key. The rule is chosen by configuration bits 1:0. Rule 0 expects the stored key (written at address 1). Rule 1 expects the stored key rotated left by one bit. Rule 2 expects 0x55AA. Rule 3 expects the stored key shifted left by one, with bit 15 XOR bit 0 of the stored key placed in bit 0. A match grants the unlock.
- R7: An unlock write that does not match sets unl_fail_flag and leaves no unlock held.
- R8: With the timeout enable (configuration bit 3) set, a refresh that comes k cycles after the unlock edge is accepted only if k is at most the period written at address 2. A period of 0 rejects every refresh.
- R9: Any refresh attempt, whether accepted or rejected, consumes the held unlock.
- R10: A write to address 5 clears viol_flag where data bit 0 is one, and clears unl_fail_flag where data bit 1 is one. Zero bits leave the matching flag unchanged.
- R11: irq is high when viol_flag is set with configuration bit 4 set, or when unl_fail_flag is set with bit 6 set. rst_req is high when viol_flag is set with bit 5 set, or when unl_fail_flag is set with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| window_ok | input | 1 | Counter core reports the counter is inside the refresh window |
| refresh_ok | output | 1 | One-cycle accepted-refresh strobe to the counter core |
| viol_flag | output | 1 | Sticky refresh violation flag |
| unl_fail_flag | output | 1 | Sticky unlock failure flag |
| irq | output | 1 | Gated interrupt request |
| rst_req | output | 1 | Gated reset request |

## Verification
On every cycle, the assertions check the following: a refresh strobe always follows a magic-word write made while the window was open; a wrong word, a closed window or a locked refresh always sets the violation flag without a strobe; a bad unlock key always sets the fail flag and leaves the gate locked; a refresh attempt always consumes the unlock; and the flags fall only on a matching clear write. Only the bench scenarios can show the rest. These are the four key derivation rules with concrete values, the exact edge of the timeout period (accepted at k equal to the period, rejected one cycle later), and the gating of the interrupt and reset requests as the enables change.

// File: rtl/refresh_gate.sv
module refresh_gate #(
  parameter int KEY_W  = 16,
  parameter int TMR_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] MAGIC     = 32'h5A45524F,
  parameter logic [KEY_W-1:0]  FIXED_KEY = 16'h55AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              window_ok,
  output logic              refresh_ok,
  output logic              viol_flag,
  output logic              unl_fail_flag,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] A_KEY = 3'd1;
  localparam logic [ADDR_W-1:0] A_PER = 3'd2;
  localparam logic [ADDR_W-1:0] A_UNL = 3'd3;
  localparam logic [ADDR_W-1:0] A_REF = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR = 3'd5;

  logic [7:0]       cfg;
  logic [KEY_W-1:0] stored;
  logic [TMR_W-1:0] period;
  logic [TMR_W-1:0] tmr;
  logic             unlocked;
  logic [KEY_W-1:0] expected_key;

  wire [1:0] rule     = cfg[1:0];
  wire       lock_en  = cfg[2];
  wire       to_en    = cfg[3];
  wire       wr_unl   = wr_en && (wr_addr == A_UNL);
  wire       wr_ref   = wr_en && (wr_addr == A_REF);
  wire       wr_clr   = wr_en && (wr_addr == A_CLR);
  wire       key_match = (wr_data[KEY_W-1:0] == expected_key);
  wire       in_time  = !to_en || (tmr != '0);
  wire       ref_good = (wr_data == MAGIC) && window_ok &&
                        (!lock_en || (unlocked && in_time));

  always_comb begin
    case (rule)
      2'd0:    expected_key = stored;
      2'd1:    expected_key = {stored[KEY_W-2:0], stored[KEY_W-1]};
      2'd2:    expected_key = FIXED_KEY;
      default: expected_key = {stored[KEY_W-2:0], stored[KEY_W-1] ^ stored[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      stored <= '0;
      period <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CFG) cfg    <= wr_data[7:0];
      if (wr_addr == A_KEY) stored <= wr_data[KEY_W-1:0];
      if (wr_addr == A_PER) period <= wr_data[TMR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      tmr      <= '0;
    end else if (wr_unl) begin
      unlocked <= key_match;
      tmr      <= period;
    end else if (wr_ref) begin
      unlocked <= 1'b0;
    end else if (unlocked && tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_ok    <= 1'b0;
      viol_flag     <= 1'b0;
      unl_fail_flag <= 1'b0;
    end else begin
      refresh_ok <= wr_ref && ref_good;
      if (wr_ref && !ref_good)        viol_flag <= 1'b1;
      else if (wr_clr && wr_data[0])  viol_flag <= 1'b0;
      if (wr_unl && !key_match)       unl_fail_flag <= 1'b1;
      else if (wr_clr && wr_data[1])  unl_fail_flag <= 1'b0;
    end
  end

  assign irq     = (viol_flag && cfg[4]) || (unl_fail_flag && cfg[6]);
  assign rst_req = (viol_flag && cfg[5]) || (unl_fail_flag && cfg[7]);

  assert_ok_needs_magic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |-> $past(wr_en && wr_addr == A_REF && wr_data == MAGIC && window_ok));
  assert_bad_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ref && wr_data != MAGIC) |=> (viol_flag && !refresh_ok));
  assert_window_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ref && !window_ok) |=> (viol_flag && !refresh_ok));
  assert_locked_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ref && lock_en && !unlocked) |=> (viol_flag && !refresh_ok));
  assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unl && !key_match) |=> (unl_fail_flag && !unlocked));
  assert_unlock_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |=> !unlocked);
  assert_viol_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol_flag) |-> $past(wr_en && wr_addr == A_CLR && wr_data[0]));
  assert_fail_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unl_fail_flag) |-> $past(wr_en && wr_addr == A_CLR && wr_data[1]));
endmodule

// File: tb/refresh_gate_test.sv
module refresh_gate_test;
  localparam logic [31:0] MAGIC = 32'h5A45524F;
  localparam logic [15:0] PW    = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        window_ok = 1'b1;
  logic        refresh_ok, viol_flag, unl_fail_flag, irq, rst_req;

  int total = 0;
  int fails = 0;
  string cur_req = "R1";

  refresh_gate uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .window_ok(window_ok), .refresh_ok(refresh_ok), .viol_flag(viol_flag),
    .unl_fail_flag(unl_fail_flag), .irq(irq), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_cfg, m_pw, m_per, m_p0, m_cyc, m_t0, m_ok, m_viol, m_fail, m_unl;

  function automatic int want_key(int cfg, int pw);
    case (cfg & 3)
      0: return pw;
      1: return ((pw << 1) | (pw >> 15)) & 16'hFFFF;
      2: return 16'h55AA;
      default: return ((pw << 1) & 16'hFFFF) | (((pw >> 15) ^ pw) & 1);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_pw = 0; m_per = 0; m_p0 = 0; m_cyc = 0; m_t0 = 0;
      m_ok = 0; m_viol = 0; m_fail = 0; m_unl = 0;
    end else begin
      m_ok = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_cfg = int'(wr_data & 32'hFF);
          3'd1: m_pw  = int'(wr_data & 32'hFFFF);
          3'd2: m_per = int'(wr_data & 32'hFFFF);
          3'd3: if (int'(wr_data & 32'hFFFF) == want_key(m_cfg, m_pw)) begin
                  m_unl = 1; m_t0 = m_cyc; m_p0 = m_per;
                end else begin
                  m_unl = 0; m_fail = 1;
                end
          3'd4: begin
                  bit good;
                  good = (wr_data == MAGIC) && window_ok;
                  if (m_cfg & 4)
                    good = good && m_unl == 1 && (((m_cfg & 8) == 0) || (m_cyc - m_t0) <= m_p0);
                  if (good) m_ok = 1; else m_viol = 1;
                  m_unl = 0;
                end
          3'd5: begin
                  if (wr_data[0]) m_viol = 0;
                  if (wr_data[1]) m_fail = 0;
                end
          default: ;
        endcase
      end
      m_cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_irq, e_rst;
      e_irq = ((m_viol && (m_cfg & 16)) || (m_fail && (m_cfg & 64))) ? 1 : 0;
      e_rst = ((m_viol && (m_cfg & 32)) || (m_fail && (m_cfg & 128))) ? 1 : 0;
      total++;
      if (refresh_ok !== m_ok[0] || viol_flag !== m_viol[0] || unl_fail_flag !== m_fail[0] ||
          irq !== e_irq[0] || rst_req !== e_rst[0]) begin
        fails++;
        $display("FAIL %s model: got ok=%b v=%b f=%b irq=%b rst=%b expected ok=%0d v=%0d f=%0d irq=%0d rst=%0d",
                 cur_req, refresh_ok, viol_flag, unl_fail_flag, irq, rst_req,
                 m_ok, m_viol, m_fail, e_irq, e_rst);
      end
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgw(int rule, int lock, int to, int en4);
    return 32'(rule | (lock << 2) | (to << 3) | (en4 << 4));
  endfunction

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 ok", refresh_ok, 0); chk("R1 viol", viol_flag, 0);
    chk("R1 fail", unl_fail_flag, 0); chk("R1 irq", irq, 0); chk("R1 rst", rst_req, 0);

    cur_req = "R2";
    wr(3'd4, MAGIC);
    chk("R2 strobe", refresh_ok, 1);
    idle(1);
    chk("R2 single cycle", refresh_ok, 0);

    cur_req = "R3";
    wr(3'd4, 32'h5A45524E);
    chk("R3 viol", viol_flag, 1); chk("R3 no strobe", refresh_ok, 0);
    cur_req = "R10";
    wr(3'd5, 32'h2);
    chk("R10 bit1 keeps viol", viol_flag, 1);
    wr(3'd5, 32'h1);
    chk("R10 cleared", viol_flag, 0);

    cur_req = "R4";
    window_ok = 1'b0;
    wr(3'd4, MAGIC);
    window_ok = 1'b1;
    chk("R4 viol", viol_flag, 1); chk("R4 no strobe", refresh_ok, 0);
    wr(3'd5, 32'h1);

    cur_req = "R5";
    wr(3'd0, cfgw(0, 1, 0, 0));
    wr(3'd4, MAGIC);
    chk("R5 viol", viol_flag, 1); chk("R5 no strobe", refresh_ok, 0);
    wr(3'd5, 32'h1);

    cur_req = "R6";
    wr(3'd1, 32'(PW));
    for (int r = 0; r < 4; r++) begin
      logic [15:0] k;
      case (r)
        0: k = 16'hC3A5;
        1: k = 16'h874B;
        2: k = 16'h55AA;
        default: k = 16'h874A;
      endcase
      wr(3'd0, cfgw(r, 1, 0, 0));
      wr(3'd3, 32'(k));
      chk("R6 key accepted", unl_fail_flag, 0);
      wr(3'd4, MAGIC);
      chk("R6 refresh after unlock", refresh_ok, 1);
    end

    cur_req = "R7";
    wr(3'd0, cfgw(1, 1, 0, 0));
    wr(3'd3, 32'(PW));
    chk("R7 fail flag", unl_fail_flag, 1);
    wr(3'd4, MAGIC);
    chk("R7 still locked", viol_flag, 1);
    wr(3'd5, 32'h3);

    cur_req = "R8";
    wr(3'd2, 32'd5);
    wr(3'd0, cfgw(0, 1, 1, 0));
    wr(3'd3, 32'(PW));
    idle(4);
    wr(3'd4, MAGIC);
    chk("R8 at period", refresh_ok, 1);
    wr(3'd3, 32'(PW));
    idle(5);
    wr(3'd4, MAGIC);
    chk("R8 past period", viol_flag, 1); chk("R8 no strobe", refresh_ok, 0);
    wr(3'd5, 32'h1);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'(PW));
    wr(3'd4, MAGIC);
    chk("R8 zero period", viol_flag, 1);
    wr(3'd5, 32'h1);

    cur_req = "R9";
    wr(3'd0, cfgw(0, 1, 0, 0));
    wr(3'd3, 32'(PW));
    wr(3'd4, MAGIC);
    chk("R9 first", refresh_ok, 1);
    wr(3'd4, MAGIC);
    chk("R9 second consumed", viol_flag, 1);
    wr(3'd5, 32'h1);
    wr(3'd3, 32'(PW));
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h1);
    wr(3'd4, MAGIC);
    chk("R9 failed attempt consumes", viol_flag, 1);
    wr(3'd5, 32'h1);

    cur_req = "R11";
    wr(3'd0, 32'h30);
    wr(3'd4, 32'h1);
    chk("R11 irq", irq, 1); chk("R11 rst", rst_req, 1);
    wr(3'd0, 32'h10);
    chk("R11 rst gated", rst_req, 0); chk("R11 irq kept", irq, 1);
    wr(3'd0, 32'h00);
    chk("R11 irq gated", irq, 0); chk("R11 flag kept", viol_flag, 1);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'hC0);
    wr(3'd3, 32'h0);
    chk("R11 fail irq", irq, 1); chk("R11 fail rst", rst_req, 1);
    wr(3'd5, 32'h2);
    chk("R11 cleared irq", irq, 0); chk("R10 fail cleared", unl_fail_flag, 0);

    idle(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule